// File: doc/BRIEF.md
# Track Select Decoder with Fault Flag

This block turns a binary track number, sent by a storage controller, into a one-hot select vector for the heads of a rotating-drum memory. It also checks its own output. A single-cycle change strobe captures a new address. On the first word-time tick after the strobe, the registered select vector is replaced with the decoded one-hot pattern. On the second word-time tick, a fault flag is computed from that registered vector and the captured address. The flag is raised when the vector is empty, when it holds more than one bit, or when the address lies past the last track.

Both outputs keep their values between updates. A test input can corrupt the vector at the moment it is loaded, either by removing the decoded bit or by adding a second bit. This lets the empty-vector and multiple-bit detection be exercised from the pins.

Top module: `track_select_decoder`

## Requirements
- R1: For an address from 0 to 384 with no corruption, the select vector holds exactly one set bit, and it sits at bit position equal to the address (bit i selects track i).
- R2: The select vector keeps its old value in the cycle after the strobe. It takes the newly decoded value on the first cycle in which the word tick is high after the strobe cycle. This is one word time, well inside the eight-word-time limit.
- R3: The fault flag keeps its old value through the first word tick after a strobe. It takes its new value on the second word tick after the strobe, so it settles within two word times.
- R4: The fault flag is 1 after evaluation when the registered select vector has no bit set.
- R5: The fault flag is 1 after evaluation when the registered select vector has two or more bits set.
- R6: Addresses 385 to 511 load an all-zero select vector, and the fault flag is 1 after evaluation.
- R7: The fault flag is 0 after evaluation when exactly one bit is set and the address is at most 384.
- R8: Word ticks that arrive with no change pending leave both the select vector and the fault flag unchanged.
- R9: A new strobe that arrives before the second tick restarts the sequence. Only the latest captured address is decoded and evaluated.
- R10: While reset is high, and after it is released, the select vector is all zero and the fault flag is 0, until the first strobe is processed.
- R11: The corruption mode is sampled on the select-update tick. The encoding is: 2'b00 no change; 2'b01 clear the decoded bit; 2'b10 also set bit inj_idx_i; 2'b11 behaves like 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_addr_i | input | ADDR_W (9) | Binary track number, captured on the strobe |
| addr_chg_i | input | 1 | Single-cycle address-change strobe |
| word_tick_i | input | 1 | One-cycle pulse per word time |
| inj_kind_i | input | 2 | Test corruption mode applied at the select load |
| inj_idx_i | input | IDX_W (9) | Bit index used by the extra-bit mode |
| trk_sel_o | output | NUM_TRK (385) | Registered one-hot track select |
| trk_err_o | output | 1 | Registered track fault status |

## Verification
The assertions assume that the strobe is a pulse and that the word tick is never high in the same cycle as a strobe. They also assume that the extra-bit mode never names the bit that is already decoded, because a one-hot check under corruption would otherwise give an ambiguous result. The stimulus keeps to these conditions: every strobe lasts one cycle, every tick is issued at least one cycle after the strobe, and extra-bit indices are chosen away from the address under test. The restart case places two strobes back to back with no tick between them. Idle-tick cases pulse the tick with nothing pending.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  // Corruption modes applied to the select vector when it is loaded.
  typedef enum logic [1:0] {
    INJ_NONE  = 2'b00,
    INJ_DROP  = 2'b01,
    INJ_EXTRA = 2'b10,
    INJ_RSVD  = 2'b11
  } inj_kind_e;

  // Sequencer states after an address change.
  typedef enum logic [1:0] {
    SQ_IDLE     = 2'b00,
    SQ_WAIT_SEL = 2'b01,
    SQ_WAIT_CHK = 2'b10
  } seq_state_e;

endpackage

// File: rtl/tsd_seq.sv
module tsd_seq
  import tsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic chg_i,
  input  logic tick_i,
  output logic sel_load_o,
  output logic chk_load_o
);

  seq_state_e state_q;

  // A strobe always wins over a tick in the same cycle.
  assign sel_load_o = (state_q == SQ_WAIT_SEL) && tick_i && !chg_i;
  assign chk_load_o = (state_q == SQ_WAIT_CHK) && tick_i && !chg_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
    end else if (chg_i) begin
      state_q <= SQ_WAIT_SEL;
    end else if (sel_load_o) begin
      state_q <= SQ_WAIT_CHK;
    end else if (chk_load_o) begin
      state_q <= SQ_IDLE;
    end
  end

  // Sequencer checks.
  p_loads_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_load_o, chk_load_o}));

  p_strobe_restarts_r9: assert property (@(posedge clk) disable iff (rst)
    chg_i |=> (state_q == SQ_WAIT_SEL));

  p_chk_after_sel_r3: assert property (@(posedge clk) disable iff (rst)
    sel_load_o |=> !sel_load_o);

  p_idle_no_load_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_IDLE) |-> !(sel_load_o || chk_load_o));

endmodule

// File: rtl/tsd_addr_decode.sv
module tsd_addr_decode
  import tsd_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int NUM_TRK = 385,
  parameter int IDX_W   = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               load_i,
  input  logic [1:0]         inj_kind_i,
  input  logic [IDX_W-1:0]   inj_idx_i,
  output logic [NUM_TRK-1:0] sel_o
);

  localparam int MAX_TRK = NUM_TRK - 1;

  inj_kind_e              kind;
  logic [NUM_TRK-1:0]     dec;
  logic [NUM_TRK-1:0]     extra;
  logic [NUM_TRK-1:0]     sel_d;
  logic [NUM_TRK-1:0]     sel_q;

  assign kind = inj_kind_e'(inj_kind_i);

  // One comparator per track for the decode and for the extra-bit position.
  for (genvar i = 0; i < NUM_TRK; i++) begin : g_trk
    assign dec[i]   = (addr_i == ADDR_W'(i));
    assign extra[i] = (inj_idx_i == IDX_W'(i));
  end

  always_comb begin
    unique case (kind)
      INJ_DROP:  sel_d = '0;
      INJ_EXTRA: sel_d = dec | extra;
      default:   sel_d = dec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (load_i) begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  // Shadow state kept only for the checks below.
  logic              loaded_q;
  logic              inj_q;
  logic [ADDR_W-1:0] ld_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q  <= 1'b0;
      inj_q     <= 1'b0;
      ld_addr_q <= '0;
    end else if (load_i) begin
      loaded_q  <= 1'b1;
      inj_q     <= (kind == INJ_DROP) || (kind == INJ_EXTRA);
      ld_addr_q <= addr_i;
    end
  end

  p_onehot_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    (loaded_q && !inj_q && (ld_addr_q <= ADDR_W'(MAX_TRK)))
      |-> ($countones(sel_q) == 1 && sel_q[ld_addr_q]));

  p_zero_out_of_range_r6: assert property (@(posedge clk) disable iff (rst)
    (loaded_q && !inj_q && (ld_addr_q > ADDR_W'(MAX_TRK))) |-> (sel_q == '0));

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(sel_q));

  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (sel_q == '0));

endmodule

// File: rtl/tsd_hot_check.sv
module tsd_hot_check #(
  parameter int ADDR_W  = 9,
  parameter int NUM_TRK = 385
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [NUM_TRK-1:0] sel_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               err_o
);

  localparam int                 MAX_TRK = NUM_TRK - 1;
  localparam logic [NUM_TRK-1:0] ONE_V   = NUM_TRK'(1);

  logic zero_hot;
  logic multi_hot;
  logic bad_range;
  logic err_q;

  // Clearing the lowest set bit leaves something only if two or more were set.
  assign zero_hot  = ~|sel_i;
  assign multi_hot = |(sel_i & (sel_i - ONE_V));
  assign bad_range = (addr_i > ADDR_W'(MAX_TRK));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (load_i) begin
      err_q <= zero_hot | multi_hot | bad_range;
    end
  end

  assign err_o = err_q;

  p_err_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && ($countones(sel_i) == 0)) |=> err_q);

  p_err_multi_r5: assert property (@(posedge clk) disable iff (rst)
    (load_i && ($countones(sel_i) > 1)) |=> err_q);

  p_err_range_r6: assert property (@(posedge clk) disable iff (rst)
    (load_i && (addr_i > ADDR_W'(MAX_TRK))) |=> err_q);

  p_err_clean_r7: assert property (@(posedge clk) disable iff (rst)
    (load_i && ($countones(sel_i) == 1) && (addr_i <= ADDR_W'(MAX_TRK))) |=> !err_q);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(err_q));

endmodule

// File: rtl/track_select_decoder.sv
module track_select_decoder #(
  parameter int ADDR_W  = 9,
  parameter int NUM_TRK = 385,
  parameter int IDX_W   = $clog2(NUM_TRK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  trk_addr_i,
  input  logic               addr_chg_i,
  input  logic               word_tick_i,
  input  logic [1:0]         inj_kind_i,
  input  logic [IDX_W-1:0]   inj_idx_i,
  output logic [NUM_TRK-1:0] trk_sel_o,
  output logic               trk_err_o
);

  logic [ADDR_W-1:0] addr_q;
  logic              sel_load;
  logic              chk_load;

  // Address capture on the change strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (addr_chg_i) begin
      addr_q <= trk_addr_i;
    end
  end

  tsd_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .chg_i      (addr_chg_i),
    .tick_i     (word_tick_i),
    .sel_load_o (sel_load),
    .chk_load_o (chk_load)
  );

  tsd_addr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_TRK (NUM_TRK),
    .IDX_W   (IDX_W)
  ) u_dec (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_q),
    .load_i     (sel_load),
    .inj_kind_i (inj_kind_i),
    .inj_idx_i  (inj_idx_i),
    .sel_o      (trk_sel_o)
  );

  tsd_hot_check #(
    .ADDR_W  (ADDR_W),
    .NUM_TRK (NUM_TRK)
  ) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load_i (chk_load),
    .sel_i  (trk_sel_o),
    .addr_i (addr_q),
    .err_o  (trk_err_o)
  );

  p_addr_capture_r9: assert property (@(posedge clk) disable iff (rst)
    addr_chg_i |=> (addr_q == $past(trk_addr_i)));

  p_err_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> !trk_err_o);

endmodule

// File: tb/tb_track_select_decoder.sv
module tb_track_select_decoder;

  localparam int N  = 385;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] trk_addr_i = '0;
  logic          addr_chg_i = 1'b0;
  logic          word_tick_i = 1'b0;
  logic [1:0]    inj_kind_i = 2'b00;
  logic [AW-1:0] inj_idx_i = '0;
  logic [N-1:0]  trk_sel_o;
  logic          trk_err_o;

  always #10 clk = ~clk;

  track_select_decoder dut (
    .clk         (clk),
    .rst         (rst),
    .trk_addr_i  (trk_addr_i),
    .addr_chg_i  (addr_chg_i),
    .word_tick_i (word_tick_i),
    .inj_kind_i  (inj_kind_i),
    .inj_idx_i   (inj_idx_i),
    .trk_sel_o   (trk_sel_o),
    .trk_err_o   (trk_err_o)
  );

  typedef struct {
    logic [N-1:0] sel;
    logic         err;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  event         mon_ev;
  int           total = 0;
  int           bad = 0;
  bit           done = 0;
  logic [N-1:0] prev_sel = '0;
  logic         prev_err = 1'b0;

  task automatic chk_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sel act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: err act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [AW-1:0] a, input logic [1:0] k,
                                 input logic [AW-1:0] idx, input string tag);
    exp_t e;
    e.sel = '0;
    if (a <= AW'(N - 1)) e.sel[a] = 1'b1;
    if (k == 2'b01) e.sel = '0;
    if (k == 2'b10 && idx <= AW'(N - 1)) e.sel[idx] = 1'b1;
    e.err = ($countones(e.sel) != 1) || (a > AW'(N - 1));
    e.tag = tag;
    return e;
  endfunction

  task automatic tick_pulse(input logic [1:0] k, input logic [AW-1:0] idx);
    @(negedge clk);
    word_tick_i = 1'b1;
    inj_kind_i  = k;
    inj_idx_i   = idx;
    @(negedge clk);
    word_tick_i = 1'b0;
    inj_kind_i  = 2'b00;
  endtask

  // Driver: one or two strobes, then the two word ticks; expected result queued.
  task automatic do_change(input logic [AW-1:0] a, input logic [1:0] k,
                           input logic [AW-1:0] idx, input string tag,
                           input bit restart, input logic [AW-1:0] first_a);
    exp_t e;
    e = model(a, k, idx, tag);
    @(negedge clk);
    trk_addr_i = restart ? first_a : a;
    addr_chg_i = 1'b1;
    if (restart) begin
      @(negedge clk);
      trk_addr_i = a;   // R9: second strobe before any tick
    end
    @(negedge clk);
    addr_chg_i = 1'b0;
    chk_vec({tag, " R2 no update before tick"}, trk_sel_o, prev_sel);
    tick_pulse(k, idx);
    chk_vec({tag, " R2 select after first tick"}, trk_sel_o, e.sel);
    chk_bit({tag, " R3 flag held after first tick"}, trk_err_o, prev_err);
    sb.push_back(e);
    tick_pulse(2'b00, '0);
    ->mon_ev;
    prev_sel = e.sel;
    prev_err = e.err;
  endtask

  // Monitor: pops the expected item once the flag has been evaluated.
  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      #1;
      if (sb.size() == 0) begin
        total++;
        bad++;
        $display("FAIL scoreboard: empty act=0 exp=1");
      end else begin
        e = sb.pop_front();
        chk_vec({e.tag, " select"}, trk_sel_o, e.sel);
        chk_bit({e.tag, " R3 flag after second tick"}, trk_err_o, e.err);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk_vec("R10 select in reset", trk_sel_o, '0);
    chk_bit("R10 flag in reset", trk_err_o, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk_vec("R10 select after reset", trk_sel_o, '0);
    chk_bit("R10 flag after reset", trk_err_o, 1'b0);

    do_change(9'd0,   2'b00, '0, "R1 R7 track 0",     0, '0);
    do_change(9'd200, 2'b00, '0, "R1 R7 track 200",   0, '0);
    do_change(9'd384, 2'b00, '0, "R1 R7 track 384",   0, '0);
    do_change(9'd385, 2'b00, '0, "R6 address 385",    0, '0);
    do_change(9'd129, 2'b00, '0, "R7 clean after fault", 0, '0);
    do_change(9'd511, 2'b00, '0, "R6 address 511",    0, '0);
    do_change(9'd10,  2'b01, '0, "R4 R11 drop bit",   0, '0);
    do_change(9'd5,   2'b10, 9'd300, "R5 R11 extra bit", 0, '0);
    do_change(9'd7,   2'b11, 9'd100, "R11 mode 3 inert", 0, '0);
    do_change(9'd384, 2'b10, 9'd0,   "R5 R11 extra at top", 0, '0);

    // R8: ticks with nothing pending leave both outputs unchanged.
    tick_pulse(2'b01, '0);
    tick_pulse(2'b10, 9'd3);
    chk_vec("R8 select stable on idle ticks", trk_sel_o, prev_sel);
    chk_bit("R8 flag stable on idle ticks", trk_err_o, prev_err);

    do_change(9'd60, 2'b00, '0, "R9 restart uses latest", 1, 9'd50);
    do_change(9'd50, 2'b00, '0, "R9 restart from range fault", 1, 9'd450);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule